// File: doc/BRIEF.md
# Bit-Serial Recirculating Accumulator

The block holds one machine word in a recirculating delay loop that advances one bit per clock, in the manner of a rotating-memory machine. A free-running bit counter marks each word time. The word-start strobe is high in the cycle where bit 0, the least significant bit, sits in the loop's output stage. The loop runs for exactly one word time under whichever command was presented at that strobe. It can add a serial operand stream into the word, load the stream in place of the word, shift the word one place in either direction, or play the word out to a memory write port. With no command the loop simply keeps its word.

Shifts change the loop length rather than moving bits through a parallel shifter. One stage is inserted for a left shift and one stage is skipped for a right shift, in each case for a single word time. A shift of n places is issued as the same one-place command over n consecutive word times. The memory write stream is taken from a tap one stage ahead of the loop output. The write window therefore opens one cycle before the word boundary, which accounts for the one-bit delay of a memory that records on the cycle after it is handed a bit.

A parallel view of the word, as aligned at the start of the current word time, is brought out for observation.

Top module: `serial_accum`

## Requirements
- R1: `wordStart` is high in the first cycle after reset is released and then exactly once every WORD_W (40) cycles. Reset clears the word, so `wordView` reads 0 and `busy` reads 0.
- R2: Command code 0 (idle) leaves the word unchanged over the word time. Codes 6 and 7 are treated as idle, and `busy` stays low for all three.
- R3: Code 1 (add) replaces the word with (word + operand) mod 2^WORD_W. The operand arrives on `opBit` least significant bit first, bit k in cycle k of the word time (cycle 0 is the strobe cycle). The carry is cleared at every strobe, so a carry out of the top bit never reaches the next word time.
- R4: Code 2 (load) replaces the word with the operand stream, taken with the same timing as in R3.
- R5: Code 3 (left shift) moves every bit one place toward the most significant end. The new bit 0 is 0 and the old top bit is lost.
- R6: Code 4 (right shift) moves every bit one place toward the least significant end. The old bit 0 becomes the new top bit, a rotation.
- R7: A shift of n places results from issuing the same shift code at n consecutive strobes.
- R8: `busy` is high in every cycle of a word time that carries code 1, 2, 3 or 4, and it changes only in strobe cycles.
- R9: Code 5 (emit) raises `memWrEn` from the last cycle of its word time for exactly WORD_W cycles. During that window `memWrData` carries the word, bit 0 first, and the word itself is left unchanged.
- R10: An emit occupies two word times with `busy` high throughout. The command presented at the strobe in between is ignored.
- R11: `cmdCode` is sampled only in strobe cycles. A value presented at any other cycle has no effect.
- R12: `wordView` equals the word as aligned at the start of the current word time and is constant between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdCode | input | 3 | Command, sampled in the strobe cycle |
| opBit | input | 1 | Serial operand, least significant bit first |
| wordStart | output | 1 | High in the cycle where bit 0 is at the loop output |
| busy | output | 1 | High during any word time doing work |
| memWrEn | output | 1 | Memory write window |
| memWrData | output | 1 | Serial write data from the early tap |
| wordView | output | WORD_W | Word as aligned at the current word start |

## Verification
A loop that slips by one stage, a stale carry or a wrong shift fill cannot be seen mid-word. It appears in `wordView` at the very next strobe, one word time after the faulty command, so every command's result is compared at the following word start against an independent word model. A tap one stage off shifts the whole memory write stream by one bit, and a wrong window start misplaces `memWrEn` against the word boundary, so every emitted bit and the window edges are compared in the cycle they appear. Commands ignored mid-word or during the second emit word would corrupt the word seen at the next strobe.

// File: rtl/serial_accum_pkg.sv
`timescale 1ns/1ps
package serial_accum_pkg;

  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    OP_IDLE = 3'd0,
    OP_ADD  = 3'd1,
    OP_LOAD = 3'd2,
    OP_SHL  = 3'd3,
    OP_SHR  = 3'd4,
    OP_EMIT = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    EM_NONE   = 2'd0,
    EM_FIRST  = 2'd1,
    EM_SECOND = 2'd2
  } emit_e;

  // strobes from control to datapath, valid for the current bit cycle
  typedef struct packed {
    logic doAdd;
    logic doLoad;
    logic doShl;
    logic doShr;
    logic first;
    logic last;
  } dp_ctl_t;

endpackage

// File: rtl/serial_accum_ctrl.sv
`timescale 1ns/1ps
module serial_accum_ctrl
  import serial_accum_pkg::*;
#(
  parameter int WORD_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmdCode,
  output dp_ctl_t          ctl,
  output logic             wordStart,
  output logic             busy,
  output logic             memWrEn
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] bitCnt;
  op_e   opQ, opNow, opDec;
  emit_e stageQ, stageNow;

  // bit position within the word time
  always_ff @(posedge clk) begin
    if (rst) bitCnt <= '0;
    else     bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  end

  assign wordStart = (bitCnt == '0);

  // unknown codes fall back to plain recirculation
  always_comb begin
    case (cmdCode)
      3'd1:    opDec = OP_ADD;
      3'd2:    opDec = OP_LOAD;
      3'd3:    opDec = OP_SHL;
      3'd4:    opDec = OP_SHR;
      3'd5:    opDec = OP_EMIT;
      default: opDec = OP_IDLE;
    endcase
  end

  // the command only takes effect at a word boundary; the word after an
  // emit word belongs to the emit and ignores the code presented
  always_comb begin
    opNow    = opQ;
    stageNow = stageQ;
    if (wordStart) begin
      if (stageQ == EM_FIRST) begin
        opNow    = OP_IDLE;
        stageNow = EM_SECOND;
      end else begin
        opNow    = opDec;
        stageNow = (opDec == OP_EMIT) ? EM_FIRST : EM_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opQ    <= OP_IDLE;
      stageQ <= EM_NONE;
    end else begin
      opQ    <= opNow;
      stageQ <= stageNow;
    end
  end

  assign busy = (opNow != OP_IDLE) || (stageNow != EM_NONE);

  // write window: last bit of the emit word, then all but the last bit of
  // the following word (the early tap leads the output by one stage)
  assign memWrEn = ((stageNow == EM_FIRST)  && (bitCnt == LAST_BIT)) ||
                   ((stageNow == EM_SECOND) && (bitCnt != LAST_BIT));

  always_comb begin
    ctl        = '0;
    ctl.doAdd  = (opNow == OP_ADD);
    ctl.doLoad = (opNow == OP_LOAD);
    ctl.doShl  = (opNow == OP_SHL);
    ctl.doShr  = (opNow == OP_SHR);
    ctl.first  = wordStart;
    ctl.last   = (bitCnt == LAST_BIT);
  end

endmodule

// File: rtl/serial_accum_dp.sv
`timescale 1ns/1ps
module serial_accum_dp
  import serial_accum_pkg::*;
#(
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_ctl_t           ctl,
  input  logic              opBit,
  output logic              memTap,
  output logic [WORD_W-1:0] wordView
);

  // loopQ[0] is the output stage; new bits enter at the top
  logic [WORD_W-1:0] loopQ, loopD;
  logic carryQ, carryD;
  logic spareQ, spareD;   // stage inserted during a left shift
  logic carryIn, feedBit;

  always_comb begin
    carryIn = ctl.first ? 1'b0 : carryQ;
    carryD  = carryQ;
    spareD  = spareQ;
    feedBit = loopQ[0];
    if (ctl.doAdd) begin
      feedBit = loopQ[0] ^ opBit ^ carryIn;
      carryD  = (loopQ[0] & opBit) | (carryIn & (loopQ[0] ^ opBit));
    end else if (ctl.doLoad) begin
      feedBit = opBit;
    end else if (ctl.doShl) begin
      // the extra stage starts the word empty, so a zero enters first
      feedBit = ctl.first ? 1'b0 : spareQ;
      spareD  = loopQ[0];
    end

    loopD = {feedBit, loopQ[WORD_W-1:1]};
    // a right shift skips one stage once per word: the loop is one shorter
    if (ctl.doShr && ctl.first)
      loopD = {loopQ[1:0], loopQ[WORD_W-1:2]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loopQ    <= '0;
      carryQ   <= 1'b0;
      spareQ   <= 1'b0;
      wordView <= '0;
    end else begin
      loopQ  <= loopD;
      carryQ <= carryD;
      spareQ <= spareD;
      if (ctl.last) wordView <= loopD;
    end
  end

  assign memTap = loopQ[1];

endmodule

// File: rtl/serial_accum.sv
`timescale 1ns/1ps
module serial_accum
  import serial_accum_pkg::*;
#(
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmdCode,
  input  logic              opBit,
  output logic              wordStart,
  output logic              busy,
  output logic              memWrEn,
  output logic              memWrData,
  output logic [WORD_W-1:0] wordView
);

  dp_ctl_t ctl;
  logic    memTap;

  serial_accum_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmdCode   (cmdCode),
    .ctl       (ctl),
    .wordStart (wordStart),
    .busy      (busy),
    .memWrEn   (memWrEn)
  );

  serial_accum_dp #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .opBit    (opBit),
    .memTap   (memTap),
    .wordView (wordView)
  );

  assign memWrData = memTap & memWrEn;

endmodule

// File: rtl/serial_accum_chk.sv
`timescale 1ns/1ps
module serial_accum_chk #(
  parameter int WORD_W = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              wordStart,
  input logic              busy,
  input logic              memWrEn,
  input logic [WORD_W-1:0] wordView
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cycCnt;
  logic              idleArmed;
  logic [WORD_W-1:0] idleSaved;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycCnt    <= '0;
      idleArmed <= 1'b0;
      idleSaved <= '0;
    end else begin
      cycCnt <= (cycCnt == LAST_BIT) ? '0 : cycCnt + 1'b1;
      if (wordStart) begin
        idleArmed <= !busy;
        idleSaved <= wordView;
      end
    end
  end

  // R1
  strobe_period_chk: assert property (@(posedge clk) disable iff (rst)
    wordStart == (cycCnt == '0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wordStart && idleArmed) |-> (wordView == idleSaved));

  // R8
  busy_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wordStart |-> $stable(busy));

  // R9
  wr_busy_chk: assert property (@(posedge clk) disable iff (rst)
    memWrEn |-> busy);

  // R9
  wr_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(memWrEn) |-> (cycCnt == LAST_BIT));

  // R12
  view_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wordStart |-> $stable(wordView));

endmodule

bind serial_accum serial_accum_chk #(.WORD_W(WORD_W)) u_serial_accum_chk (
  .clk       (clk),
  .rst       (rst),
  .wordStart (wordStart),
  .busy      (busy),
  .memWrEn   (memWrEn),
  .wordView  (wordView)
);

// File: tb/test_serial_accum.sv
`timescale 1ns/1ps
module test_serial_accum;

  localparam int W = 40;

  typedef struct {
    int unsigned  tgt;
    logic [W-1:0] val;
    string        req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   cmdCode = 3'd0;
  logic         opBit = 1'b0;
  logic         wordStart, busy, memWrEn, memWrData;
  logic [W-1:0] wordView;

  int unsigned  strobeCnt = 0;
  int           nChecks = 0;
  int           nFails = 0;
  bit           emitSecond = 0;
  bit           finished = 0;
  logic [W-1:0] acc = '0;
  exp_t         expQ[$];
  logic         memQ[$];

  serial_accum #(.WORD_W(W)) i_serial_accum (
    .clk       (clk),
    .rst       (rst),
    .cmdCode   (cmdCode),
    .opBit     (opBit),
    .wordStart (wordStart),
    .busy      (busy),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .wordView  (wordView)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) strobeCnt <= 0;
    else if (wordStart) strobeCnt <= strobeCnt + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // driver: one command per word time, expected word pushed for next strobe
  task automatic issue(input logic [2:0] code, input logic [W-1:0] operand,
                       input string req);
    logic [W-1:0] nxt;
    bit ignored;
    bit expBusy;
    int busyBad;
    ignored = emitSecond;
    expBusy = ignored || (code >= 3'd1 && code <= 3'd5);
    nxt = acc;
    if (!ignored) begin
      case (code)
        3'd1: nxt = acc + operand;
        3'd2: nxt = operand;
        3'd3: nxt = {acc[W-2:0], 1'b0};
        3'd4: nxt = {acc[0], acc[W-1:1]};
        default: nxt = acc;
      endcase
    end
    busyBad = 0;
    do @(negedge clk); while (!wordStart);
    cmdCode = code;
    opBit = operand[0];
    expQ.push_back('{strobeCnt + 1, nxt, req});
    if (code == 3'd5 && !ignored)
      for (int b = 0; b < W; b++) memQ.push_back(acc[b]);
    #1;
    if (busy !== expBusy) busyBad++;
    for (int t = 1; t < W; t++) begin
      @(negedge clk);
      cmdCode = 3'd2;              // R11: mid-word code must be ignored
      opBit = operand[t];
      #1;
      if (busy !== expBusy) busyBad++;
      if (code == 3'd5 && !ignored && t == W - 2)
        chk(memWrEn === 1'b0, "R9 window not yet open", W'(memWrEn), '0);
      if (code == 3'd5 && !ignored && t == W - 1)
        chk(memWrEn === 1'b1, "R9 window opens last cycle", W'(memWrEn), 1);
    end
    chk(busyBad == 0, ignored ? "R10 busy in second emit word" : "R8 busy over word",
        W'(busyBad), '0);
    cmdCode = 3'd0;
    emitSecond = (code == 3'd5) && !ignored;
    acc = nxt;
  endtask

  // monitor: scoreboard for word results and memory write bits
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && wordStart) begin
        while (expQ.size() > 0 && expQ[0].tgt == strobeCnt) begin
          exp_t e;
          e = expQ.pop_front();
          chk(wordView === e.val, e.req, wordView, e.val);
        end
      end
      if (!rst && memWrEn) begin
        if (memQ.size() == 0) chk(1'b0, "R9 unexpected write bit", W'(memWrData), '0);
        else begin
          logic eb;
          eb = memQ.pop_front();
          chk(memWrData === eb, "R9 write data bit", W'(memWrData), W'(eb));
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nFails++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int gap;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(wordView === '0, "R1 reset word", wordView, '0);
    chk(busy === 1'b0, "R1 reset busy", W'(busy), '0);
    chk(wordStart === 1'b1, "R1 strobe in reset", W'(wordStart), 1);
    rst = 1'b0;
    // R1: strobe period
    do @(negedge clk); while (!wordStart);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!wordStart);
    chk(gap == W, "R1 strobe period", W'(gap), W'(W));

    issue(3'd2, 40'h12_3456_789A, "R4 load");
    issue(3'd0, 40'hFF_FFFF_FFFF, "R2 R11 idle holds word");
    issue(3'd1, 40'h00_FEDC_BA98, "R3 add");
    issue(3'd2, 40'hFF_FFFF_FFFF, "R4 load ones");
    issue(3'd1, 40'h00_0000_0001, "R3 add wraps carry out");
    issue(3'd1, 40'h00_0000_0005, "R3 carry cleared");
    issue(3'd6, 40'h55_5555_5555, "R2 code 6 ignored");
    issue(3'd7, 40'hAA_AAAA_AAAA, "R2 code 7 ignored");
    issue(3'd2, 40'h80_0000_0001, "R4 load pattern");
    issue(3'd3, '0, "R5 shift left drops top");
    issue(3'd3, '0, "R7 shift left second place");
    issue(3'd3, '0, "R7 shift left third place");
    issue(3'd2, 40'h00_0000_0003, "R4 load three");
    issue(3'd4, '0, "R6 shift right rotates bit0");
    issue(3'd4, '0, "R7 shift right second place");
    issue(3'd5, '0, "R9 emit keeps word");
    issue(3'd1, 40'h00_0000_0007, "R10 command in second emit word ignored");
    issue(3'd0, '0, "R12 view after emit");
    issue(3'd0, '0, "R2 idle final");
    repeat (W + 2) @(negedge clk);
    chk(memQ.size() == 0, "R9 all write bits seen", W'(memQ.size()), '0);
    chk(expQ.size() == 0, "R12 all words compared", W'(expQ.size()), '0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule